// File: doc/BRIEF.md
# Bidirectional Port Controller with Output Register

This block controls one side of a device that holds two FIFOs running in opposite directions. The same port writes into one FIFO and reads from the other. Four control inputs are decoded into a write strobe for the outbound FIFO, a read-select for the inbound FIFO, and an enable for the tri-state driver of the 36-bit data bus. The inputs are an active-low chip select, a write/read select, an enable and a mailbox select. A parameter flips the write/read polarity, so the same module serves either side of the device.

The block also owns the inbound FIFO's read pointer and its output register. It receives the opposite side's write pointer and delays it through a parameterised chain of flip-flops. It then compares that pointer with its own read pointer to find the remaining word count. In standard mode the status flag means "words waiting in the array", and the output register loads only on an accepted read. In fall-through mode the flag means "a fresh word sits in the output register". The first word after an empty spell drops into the register on its own. The RAM array, the pointer conversion for the clock crossing and the mailbox registers live outside.

Top module: `bidir_port_ctrl`

## Requirements
- R1: The bus enable `bus_oe` is high exactly when `cs_n` is 0 and the write/read select is at its read level. The read level is `wr_rd`=0 for the first-side variant (`PORT_B`=0) and `wr_rd`=1 for the second-side variant (`PORT_B`=1).
- R2: `wr_strobe` is high exactly when all of these hold: `cs_n`=0, `wr_rd` at the write level (1 when `PORT_B`=0, 0 when `PORT_B`=1), `en`=1, `mb_sel`=0 and `wr_space`=1.
- R3: A read is accepted on a rising edge when all of these hold: `cs_n`=0, `wr_rd` at the read level, `en`=1, `mb_sel`=0 and `rd_flag`=1. An accepted read advances `rd_addr`. With `wr_rd` at the write level, no read happens.
- R4: In standard mode (`fwft_mode`=0), `rd_flag` is 1 when the remaining word count is non-zero. A change of `wr_ptr_in` reaches `rd_flag` after two rising edges.
- R5: In standard mode, `rd_dout` takes `rd_data` only on an accepted read and holds its value otherwise, even while words are waiting.
- R6: In fall-through mode (`fwft_mode`=1) with `rd_flag`=0, the first available word loads into `rd_dout` without a read. This happens on the edge that raises `rd_flag`, which is the third rising edge after `wr_ptr_in` changes.
- R7: In fall-through mode with `rd_flag`=1, `rd_dout` and `rd_flag` hold until a read is accepted. The accepted read loads the next word if one remains; otherwise it drops `rd_flag` and keeps the old word.
- R8: A read attempted while `rd_flag`=0 changes neither `rd_dout` nor `rd_addr`, in either mode.
- R9: `rd_addr` increases by one, wrapping at the array depth, each time a word enters the output register, in both modes. It never changes otherwise.
- R10: After synchronous reset, `rd_flag`=0, `rd_dout`=0 and `rd_addr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous active-high reset |
| fwft_mode | input | 1 | 0 = standard mode, 1 = fall-through mode |
| cs_n | input | 1 | Chip select, active low |
| wr_rd | input | 1 | Write/read select; polarity set by `PORT_B` |
| en | input | 1 | Port enable |
| mb_sel | input | 1 | Mailbox select; 1 blocks FIFO access |
| wr_space | input | 1 | Outbound FIFO can accept a word |
| wr_strobe | output | 1 | Write into outbound FIFO this edge |
| bus_oe | output | 1 | Drive the data bus |
| wr_ptr_in | input | ADDR_W+1 | Inbound FIFO write pointer from the other side |
| rd_addr | output | ADDR_W | Inbound array read address |
| rd_data | input | DATA_W | Array word at `rd_addr` |
| rd_dout | output | DATA_W | Output register |
| rd_flag | output | 1 | Empty flag (standard) or output-ready (fall-through) |

## Verification
The interesting overlap is in fall-through mode. A read held selected on the port can coincide with the automatic load of a word that arrives while the FIFO is empty. The bench holds the read select high before pushing a single word. On the load edge the flag is still low, so the read must be ignored. The word must appear in `rd_dout` on the third edge and be consumed only on the fourth edge, which drops the flag. A scoreboard queue matches every presented word against the order of pushes. Separate checks compare the flag timing and `rd_addr` with values computed from the edge count.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } out_mode_e;

    typedef struct packed {
        logic cs_n;
        logic wr_rd;
        logic en;
        logic mb;
    } port_ctl_t;

    typedef struct packed {
        logic oe;
        logic wr_sel;
        logic rd_sel;
    } port_dec_t;

    // Decode port controls; flip selects the second-side polarity.
    function automatic port_dec_t decode_ctl(port_ctl_t c, logic flip);
        port_dec_t d;
        logic      wr_level;
        wr_level  = flip ? ~c.wr_rd : c.wr_rd;
        d.oe      = ~c.cs_n & ~wr_level;
        d.wr_sel  = ~c.cs_n & wr_level & c.en & ~c.mb;
        d.rd_sel  = ~c.cs_n & ~wr_level & c.en & ~c.mb;
        return d;
    endfunction

endpackage

// File: rtl/bpc_decode.sv
module bpc_decode
    import bpc_pkg::*;
#(
    parameter bit PORT_B = 1'b0
) (
    input  port_ctl_t ctl,
    input  logic      wr_space,
    output logic      bus_oe,
    output logic      wr_strobe,
    output logic      rd_sel
);
    port_dec_t dec;

    always_comb begin
        dec       = decode_ctl(ctl, PORT_B);
        bus_oe    = dec.oe;
        wr_strobe = dec.wr_sel & wr_space;
        rd_sel    = dec.rd_sel;
    end
endmodule

// File: rtl/bpc_ptr_sync.sv
module bpc_ptr_sync #(
    parameter int PTR_W  = 9,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PTR_W-1:0] d,
    output logic [PTR_W-1:0] q
);
    logic [PTR_W-1:0] st [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) st[i] <= '0;
                    else     st[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) st[i] <= '0;
                    else     st[i] <= st[i-1];
                end
            end
        end
    endgenerate

    assign q = st[STAGES-1];
endmodule

// File: rtl/bpc_out_reg.sv
module bpc_out_reg
    import bpc_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 8,
    localparam int PTR_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  out_mode_e         mode,
    input  logic              rd_sel,
    input  logic [PTR_W-1:0]  wptr_sync,
    input  logic [DATA_W-1:0] ram_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] dout,
    output logic              flag
);
    logic [PTR_W-1:0]  rd_ptr;
    logic [PTR_W-1:0]  words;
    logic              have;
    logic              or_q, or_nxt;
    logic              load;
    logic [DATA_W-1:0] dout_q;

    assign words = wptr_sync - rd_ptr;
    assign have  = (words != '0);

    always_comb begin
        unique case (mode)
            MODE_FWFT: begin
                flag = or_q;
                if (!or_q) begin
                    load   = have;
                    or_nxt = have;
                end else if (rd_sel) begin
                    load   = have;
                    or_nxt = have;
                end else begin
                    load   = 1'b0;
                    or_nxt = 1'b1;
                end
            end
            default: begin
                flag   = have;
                load   = rd_sel & have;
                or_nxt = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            dout_q <= '0;
            or_q   <= 1'b0;
        end else begin
            or_q <= or_nxt;
            if (load) begin
                rd_ptr <= rd_ptr + 1'b1;
                dout_q <= ram_data;
            end
        end
    end

    assign rd_addr = rd_ptr[ADDR_W-1:0];
    assign dout    = dout_q;

    // R9: pointer moves only by single steps
    p_ptr_step_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_ptr != $past(rd_ptr)) |-> (rd_ptr == $past(rd_ptr) + 1'b1));

    // R8: read attempt with low flag and nothing waiting leaves state alone
    p_ignore_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_sel && !flag && !have) |=> ($stable(dout) && $stable(rd_ptr)));

    // R5: standard mode holds the register without an accepted read
    p_std_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_STD && !(rd_sel && flag)) |=> $stable(dout));

    // R6: fall-through raises output-ready when words are waiting
    p_fwft_rise_r6: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_FWFT && !flag && have) |=> flag);

    // R7: fall-through keeps a presented word without a read
    p_fwft_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_FWFT && $past(mode) == MODE_FWFT && flag && !rd_sel)
        |=> (flag && $stable(dout)));
endmodule

// File: rtl/bidir_port_ctrl.sv
module bidir_port_ctrl
    import bpc_pkg::*;
#(
    parameter bit PORT_B      = 1'b0,
    parameter int DATA_W      = 36,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int PTR_W      = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fwft_mode,
    input  logic              cs_n,
    input  logic              wr_rd,
    input  logic              en,
    input  logic              mb_sel,
    input  logic              wr_space,
    output logic              wr_strobe,
    output logic              bus_oe,
    input  logic [PTR_W-1:0]  wr_ptr_in,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] rd_dout,
    output logic              rd_flag
);
    port_ctl_t        ctl;
    out_mode_e        mode;
    logic             rd_sel;
    logic [PTR_W-1:0] wptr_sync;

    assign ctl  = '{cs_n: cs_n, wr_rd: wr_rd, en: en, mb: mb_sel};
    assign mode = fwft_mode ? MODE_FWFT : MODE_STD;

    bpc_decode #(.PORT_B(PORT_B)) u_dec (
        .ctl       (ctl),
        .wr_space  (wr_space),
        .bus_oe    (bus_oe),
        .wr_strobe (wr_strobe),
        .rd_sel    (rd_sel)
    );

    bpc_ptr_sync #(.PTR_W(PTR_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (wr_ptr_in),
        .q   (wptr_sync)
    );

    bpc_out_reg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .rd_sel    (rd_sel),
        .wptr_sync (wptr_sync),
        .ram_data  (rd_data),
        .rd_addr   (rd_addr),
        .dout      (rd_dout),
        .flag      (rd_flag)
    );

    // R2: a write strobe needs room and an enabled, non-mailbox access
    p_wr_gate_r2: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |-> (wr_space && !cs_n && en && !mb_sel));

    // R1: the port never drives the bus while writing
    p_oe_excl_r1: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> !wr_strobe);
endmodule

// File: tb/test_bidir_port_ctrl.sv
module test_bidir_port_ctrl;
    localparam int DW = 36;
    localparam int AW = 8;
    localparam int PW = AW + 1;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst, fwft, wr_space;
    logic a_cs_n, a_wr_rd, a_en, a_mb;
    logic b_cs_n, b_wr_rd, b_en, b_mb;
    logic a_wstb, a_oe, a_flag, b_wstb, b_oe, b_flag;
    logic [PW-1:0] wptr;
    logic [AW-1:0] a_addr, b_addr;
    logic [DW-1:0] a_dout, b_dout;
    logic [DW-1:0] mem [2**AW];

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;
    logic [DW-1:0] expq[$];

    bidir_port_ctrl #(.PORT_B(1'b0), .DATA_W(DW), .ADDR_W(AW)) i_bidir_port_ctrl (
        .clk(clk), .rst(rst), .fwft_mode(fwft), .cs_n(a_cs_n), .wr_rd(a_wr_rd),
        .en(a_en), .mb_sel(a_mb), .wr_space(wr_space), .wr_strobe(a_wstb),
        .bus_oe(a_oe), .wr_ptr_in(wptr), .rd_addr(a_addr), .rd_data(mem[a_addr]),
        .rd_dout(a_dout), .rd_flag(a_flag));

    bidir_port_ctrl #(.PORT_B(1'b1), .DATA_W(DW), .ADDR_W(AW)) i_bidir_port_ctrl_b (
        .clk(clk), .rst(rst), .fwft_mode(1'b0), .cs_n(b_cs_n), .wr_rd(b_wr_rd),
        .en(b_en), .mb_sel(b_mb), .wr_space(wr_space), .wr_strobe(b_wstb),
        .bus_oe(b_oe), .wr_ptr_in(wptr), .rd_addr(b_addr), .rd_data(mem[b_addr]),
        .rd_dout(b_dout), .rd_flag(b_flag));

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic smp();
        @(negedge clk);
    endtask

    // Scoreboard monitor for port A
    bit mon_on = 0;
    bit fired_prev = 0;
    bit flag_prev = 0;
    logic [DW-1:0] got;
    always @(negedge clk) begin
        if (mon_on && !rst) begin
            if (!fwft) begin
                if (fired_prev) begin
                    if (expq.size() == 0) chk(0, "R5 unexpected load", a_dout, 0);
                    else begin
                        got = expq.pop_front();
                        chk(a_dout === got, "R5 std read data", a_dout, got);
                    end
                end
            end else if (a_flag && (!flag_prev || fired_prev)) begin
                if (expq.size() == 0) chk(0, "R7 unexpected word", a_dout, 0);
                else begin
                    got = expq.pop_front();
                    chk(a_dout === got, "R6/R7 fwft word", a_dout, got);
                end
            end
            fired_prev = (!a_cs_n && !a_wr_rd && a_en && !a_mb) && a_flag;
            flag_prev  = a_flag;
        end
    end

    task automatic push(input logic [DW-1:0] v);
        tick();
        mem[wptr[AW-1:0]] = v;
        expq.push_back(v);
        wptr = wptr + 1'b1;
    endtask

    task automatic do_reset();
        tick();
        rst = 1'b1;
        wptr = '0;
        expq.delete();
        fired_prev = 0;
        flag_prev = 0;
        repeat (3) tick();
        rst = 1'b0;
        smp();
        chk(a_flag == 1'b0, "R10 flag", a_flag, 0);
        chk(a_dout == '0, "R10 dout", a_dout, 0);
        chk(a_addr == '0, "R10 addr", a_addr, 0);
    endtask

    task automatic a_read(input bit on);
        a_cs_n = !on; a_wr_rd = 1'b0; a_en = on; a_mb = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; fwft = 1'b0; wr_space = 1'b1; wptr = '0;
        a_cs_n = 1; a_wr_rd = 0; a_en = 0; a_mb = 0;
        b_cs_n = 1; b_wr_rd = 0; b_en = 0; b_mb = 0;
        do_reset();

        // R1 / R2 decode sweep on both polarities
        for (int i = 0; i < 16; i++) begin
            tick();
            a_cs_n = i[0]; a_wr_rd = i[1]; a_en = i[2]; a_mb = i[3];
            b_cs_n = i[0]; b_wr_rd = i[1]; b_en = i[2]; b_mb = i[3];
            #1;
            chk(a_oe == (!i[0] && !i[1]), "R1 A bus_oe", a_oe, !i[0] && !i[1]);
            chk(b_oe == (!i[0] && i[1]), "R1 B bus_oe", b_oe, !i[0] && i[1]);
            chk(a_wstb == (!i[0] && i[1] && i[2] && !i[3]), "R2 A wr_strobe", a_wstb,
                !i[0] && i[1] && i[2] && !i[3]);
            chk(b_wstb == (!i[0] && !i[1] && i[2] && !i[3]), "R2 B wr_strobe", b_wstb,
                !i[0] && !i[1] && i[2] && !i[3]);
        end
        tick();
        a_cs_n = 0; a_wr_rd = 1; a_en = 1; a_mb = 0; wr_space = 0;
        #1 chk(a_wstb == 1'b0, "R2 no space", a_wstb, 0);
        wr_space = 1;
        b_cs_n = 1; b_en = 0;

        // R8: standard mode, reads on empty
        tick(); a_read(1);
        repeat (3) smp();
        chk(a_addr == 0, "R8 empty addr", a_addr, 0);
        chk(a_dout == 0, "R8 empty dout", a_dout, 0);
        tick(); a_read(0);
        mon_on = 1;

        // R4 flag latency
        push(36'hA_1111_0001);
        smp();
        smp(); chk(a_flag == 1'b0, "R4 flag after 1 edge", a_flag, 0);
        smp(); chk(a_flag == 1'b1, "R4 flag after 2 edges", a_flag, 1);
        push(36'hA_1111_0002);
        push(36'hA_1111_0003);
        repeat (4) tick();

        // R3: port B polarity
        b_cs_n = 0; b_wr_rd = 0; b_en = 1; b_mb = 0;
        tick(); b_en = 0;
        smp(); chk(b_addr == 0, "R3 B write level no read", b_addr, 0);
        tick(); b_wr_rd = 1; b_en = 1;
        tick(); b_en = 0; b_cs_n = 1;
        smp();
        chk(b_dout == 36'hA_1111_0001, "R3 B read data", b_dout, 36'hA_1111_0001);
        chk(b_addr == 1, "R3 B addr", b_addr, 1);

        // R5/R9 port A standard reads, two extra ignored
        tick(); a_read(1);
        repeat (5) tick();
        a_read(0);
        smp();
        chk(a_addr == 3, "R9 std addr", a_addr, 3);
        chk(a_flag == 1'b0, "R4 drained flag", a_flag, 0);
        chk(a_dout == 36'hA_1111_0003, "R8 extra reads ignored", a_dout, 36'hA_1111_0003);
        push(36'hA_1111_0004);
        repeat (4) smp();
        chk(a_flag == 1'b1, "R4 flag new word", a_flag, 1);
        chk(a_dout == 36'hA_1111_0003, "R5 no load without read", a_dout, 36'hA_1111_0003);
        tick(); a_read(1);
        tick(); a_read(0);
        smp();
        chk(a_addr == 4, "R9 std addr 4", a_addr, 4);

        // fall-through mode
        mon_on = 0;
        fwft = 1'b1;
        do_reset();
        mon_on = 1;
        tick(); a_read(1);               // read held before word arrives
        push(36'hB_2222_0000);
        smp();
        smp(); chk(a_flag == 1'b0, "R6 flag after 1 edge", a_flag, 0);
        smp(); chk(a_flag == 1'b0, "R6 flag after 2 edges", a_flag, 0);
        smp(); chk(a_flag == 1'b1, "R6 flag after 3 edges", a_flag, 1);
        chk(a_dout == 36'hB_2222_0000, "R6 auto load", a_dout, 36'hB_2222_0000);
        smp(); chk(a_flag == 1'b0, "R7 last word consumed", a_flag, 0);
        chk(a_dout == 36'hB_2222_0000, "R7 old word kept", a_dout, 36'hB_2222_0000);
        tick(); a_read(0);
        push(36'hB_2222_0001);
        push(36'hB_2222_0002);
        push(36'hB_2222_0003);
        push(36'hB_2222_0004);
        repeat (6) smp();
        chk(a_flag == 1'b1, "R6 ready", a_flag, 1);
        chk(a_dout == 36'hB_2222_0001, "R6 first word only", a_dout, 36'hB_2222_0001);
        chk(a_addr == 2, "R9 fwft addr", a_addr, 2);
        repeat (2) smp();
        chk(a_dout == 36'hB_2222_0001, "R7 hold without read", a_dout, 36'hB_2222_0001);
        for (int k = 0; k < 8; k++) begin
            tick();
            a_read(k % 2 == 0);
        end
        tick(); a_read(0);
        smp();
        chk(a_flag == 1'b0, "R7 drained", a_flag, 0);
        chk(a_addr == 5, "R9 fwft addr 5", a_addr, 5);
        tick(); a_read(1);
        repeat (2) tick();
        a_read(0);
        smp();
        chk(a_dout == 36'hB_2222_0004, "R8 fwft ignored dout", a_dout, 36'hB_2222_0004);
        chk(a_addr == 5, "R8 fwft ignored addr", a_addr, 5);
        chk(expq.size() == 0, "R7 scoreboard empty", expq.size(), 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule